// File: doc/BRIEF.md
# Serial Control Port Master Sequencer

This block is an SPI master that runs control-port transactions against one slave device. A start pulse captures a 7-bit device address, a read/write flag and a count of data bytes. The block then lowers chip select and shifts out the address byte. After that it either sends data bytes taken from the host or reads data bytes from MISO. Every bit goes out most significant bit first. SCK is a divided copy of the system clock, and the block never lets it run faster than the system clock divided by 22.

All chip-select timing is counted in system clocks. The first SCK rising edge comes a fixed lead time plus half an SCK period after chip select falls. Chip select rises the same lag after the final SCK falling edge, and a short bus-free gap follows before the block reports completion. MOSI leaves the block as a data bit plus an output enable, so a pad can release the line when the master is not driving it.

On the host side the block fetches write data one byte at a time through a take strobe. It returns each read byte with a one-cycle valid strobe, and it reports its state through busy and done.

Top module: `spi_ctl_master`

## Requirements
- R1: While reset is held, and after it is released with no start, cs_n_o is 1, sck_o is 0, and mosi_oe_o, busy_o, done_o, rd_valid_o and wr_take_o are all 0.
- R2: The divide ratio is div_i with bit 0 cleared, raised to 22 when it is smaller. It is captured at start. Each SCK high phase and each SCK low phase lasts exactly half of this ratio in system clocks. SCK stays low while chip select is high.
- R3: The first SCK rising edge comes exactly 11 + ratio/2 system clocks after cs_n_o falls.
- R4: cs_n_o rises exactly 11 + ratio/2 system clocks after the final SCK falling edge of the transaction.
- R5: done_o is high for one cycle, exactly 3 system clocks after cs_n_o rises. busy_o is 1 when cs_n_o rises and is 0 in the done cycle.
- R6: The first byte on MOSI holds the address bits A6..A0 followed by the R/W flag (1 = read). Every byte is sent MSB first. A transaction has 8 x (nbytes_i + 1) SCK pulses, so a count of 0 gives an address-only transaction.
- R7: MOSI changes only together with an SCK falling edge. In a write, data byte k (counting from 0) is the value of wdata_i in the cycle wr_take_o pulses for the k-th time. wr_take_o pulses once for each data byte, in the cycle of the SCK falling edge that ends the byte before it. In a read it never pulses.
- R8: mosi_oe_o is 1 from the fall of chip select through the last bit that the master drives: the whole frame for a write, the address byte only for a read. It is 0 after the final SCK falling edge and whenever cs_n_o is high.
- R9: MISO is sampled on the SCK rising edge. In a read, rd_valid_o pulses once for each data byte, in the cycle of the SCK falling edge that ends that byte. rd_data_o holds the byte in that cycle, MSB first as received.
- R10: A start_i pulse while busy_o is 1 is ignored. The running frame is unchanged, and chip select does not fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Requested SCK divide ratio in system clocks |
| start_i | input | 1 | Begin a transaction (honoured only when idle) |
| addr_i | input | 7 | Device address |
| rnw_i | input | 1 | 1 = read, 0 = write |
| nbytes_i | input | CNT_W | Number of data bytes after the address byte |
| wdata_i | input | 8 | Next write byte, taken when wr_take_o pulses |
| wr_take_o | output | 1 | Write byte consumed |
| rd_data_o | output | 8 | Last received byte |
| rd_valid_o | output | 1 | rd_data_o holds a new byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave |
| mosi_oe_o | output | 1 | Output enable for MOSI |
| miso_i | input | 1 | Serial data from the slave |

## Verification
The assertions assume that start_i, addr_i, rnw_i, nbytes_i and div_i are driven from the system clock domain. They also assume that miso_i is stable at the system clock edge where SCK rises. Apart from that, they assume only the reset behaviour. The stimulus drives all host inputs on the falling system clock edge. Its slave model moves MISO only when chip select falls or in the system cycle that follows an SCK falling edge, so MISO never changes near a sampling edge. One start pulse is deliberately placed in the middle of a busy transaction, to show that it is dropped rather than queued.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_XFER, ST_LAG, ST_GAP
  } seq_state_e;
endpackage

// File: rtl/spi_div_calc.sv
module spi_div_calc #(
  parameter int DIV_W   = 8,
  parameter int MIN_DIV = 22
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] half_o
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_DIV);
  logic [DIV_W-1:0] even_w, eff_w;
  always_comb begin
    even_w = {div_i[DIV_W-1:1], 1'b0};
    eff_w  = (even_w < MIN_V) ? MIN_V : even_w;
    half_o = eff_w >> 1;
  end
endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] load_val_i,
  input  logic          shift_tx_i,
  input  logic          sample_i,
  input  logic          miso_i,
  output logic          tx_msb_o,
  output logic [BW-1:0] rx_o
);
  logic [BW-1:0] tx_q, rx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load_i)          tx_q <= load_val_i;
      else if (shift_tx_i) tx_q <= {tx_q[BW-2:0], 1'b0};
      if (sample_i)        rx_q <= {rx_q[BW-2:0], miso_i};
    end
  end
  assign tx_msb_o = tx_q[BW-1];
  assign rx_o     = rx_q;
endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
  import spi_ctl_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 3,
  parameter int MIN_DIV  = 22,
  parameter int LEAD_CYC = 11,
  parameter int GAP_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rnw_i,
  input  logic [CNT_W-1:0]  nbytes_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              wr_take_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i
);
  localparam int TMR_W = DIV_W + 1;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  seq_state_e        state_q;
  logic [DIV_W-1:0]  half_w, half_q;
  logic [CNT_W-1:0]  nb_q, byte_idx_q;
  logic [BIT_W-1:0]  bit_idx_q;
  logic              rnw_q, sck_q, cs_n_q, oe_q;
  logic              rd_valid_q, wr_take_q, done_q;
  logic [BYTE_W-1:0] rd_data_q, rx_w;

  logic tmr_zero, tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic accept, rise, fall, byte_end, last_byte, next_byte, lag_end, gap_end;
  logic tx_load, tx_shift;
  logic [BYTE_W-1:0] tx_val;

  spi_div_calc #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_div (
    .div_i (div_i),
    .half_o(half_w)
  );

  spi_phase_timer #(.W(TMR_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tmr_zero)
  );

  spi_shift #(.BW(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tx_load),
    .load_val_i(tx_val),
    .shift_tx_i(tx_shift),
    .sample_i  (rise),
    .miso_i    (miso_i),
    .tx_msb_o  (mosi_o),
    .rx_o      (rx_w)
  );

  always_comb begin
    accept    = (state_q == ST_IDLE) && start_i;
    rise      = tmr_zero && (state_q == ST_LEAD || (state_q == ST_XFER && !sck_q));
    fall      = tmr_zero && state_q == ST_XFER && sck_q;
    byte_end  = fall && (bit_idx_q == LAST_BIT);
    last_byte = byte_end && (byte_idx_q == nb_q);
    next_byte = byte_end && !last_byte;
    lag_end   = tmr_zero && state_q == ST_LAG;
    gap_end   = tmr_zero && state_q == ST_GAP;

    tmr_load = 1'b1;
    tmr_val  = '0;
    if (accept)         tmr_val = TMR_W'(LEAD_CYC) + TMR_W'(half_w) - TMR_W'(1);
    else if (last_byte) tmr_val = TMR_W'(LEAD_CYC) + TMR_W'(half_q) - TMR_W'(1);
    else if (rise || fall) tmr_val = TMR_W'(half_q) - TMR_W'(1);
    else if (lag_end)   tmr_val = TMR_W'(GAP_CYC - 1);
    else                tmr_load = 1'b0;

    tx_load  = accept || next_byte;
    tx_val   = accept ? {addr_i, rnw_i} : wdata_i;
    tx_shift = fall && !byte_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      half_q     <= '0;
      nb_q       <= '0;
      byte_idx_q <= '0;
      bit_idx_q  <= '0;
      rnw_q      <= 1'b0;
      sck_q      <= 1'b0;
      cs_n_q     <= 1'b1;
      oe_q       <= 1'b0;
      rd_valid_q <= 1'b0;
      wr_take_q  <= 1'b0;
      done_q     <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      wr_take_q  <= 1'b0;
      done_q     <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q    <= ST_LEAD;
          cs_n_q     <= 1'b0;
          oe_q       <= 1'b1;
          rnw_q      <= rnw_i;
          nb_q       <= nbytes_i;
          half_q     <= half_w;
          byte_idx_q <= '0;
          bit_idx_q  <= '0;
        end
        ST_LEAD: if (rise) begin
          sck_q   <= 1'b1;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          if (rise) sck_q <= 1'b1;
          if (fall) begin
            sck_q <= 1'b0;
            if (byte_end) begin
              bit_idx_q <= '0;
              if (rnw_q && byte_idx_q != '0) begin
                rd_valid_q <= 1'b1;
                rd_data_q  <= rx_w;
              end
              if (last_byte) begin
                oe_q    <= 1'b0;
                state_q <= ST_LAG;
              end else begin
                byte_idx_q <= byte_idx_q + CNT_W'(1);
                oe_q       <= !rnw_q;
                wr_take_q  <= !rnw_q;
              end
            end else begin
              bit_idx_q <= bit_idx_q + BIT_W'(1);
            end
          end
        end
        ST_LAG: if (lag_end) begin
          cs_n_q  <= 1'b1;
          state_q <= ST_GAP;
        end
        ST_GAP: if (gap_end) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign cs_n_o     = cs_n_q;
  assign sck_o      = sck_q;
  assign mosi_oe_o  = oe_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign wr_take_o  = wr_take_q;
endmodule

// File: rtl/spi_ctl_master_chk.sv
module spi_ctl_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_n_o,
  input logic sck_o,
  input logic mosi_oe_o,
  input logic rd_valid_o,
  input logic wr_take_o
);
  a_r2_sck_low_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sck_o);
  a_r2_phase_min_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o != $past(sck_o)) |=> $stable(sck_o));
  a_r8_released_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !mosi_oe_o);
  a_r10_select_only_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> !$past(busy_o));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && !busy_o));
  a_r9_valid_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (!cs_n_o && !sck_o && !wr_take_o));
  a_r7_take_while_driving: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_take_o |-> (mosi_oe_o && !sck_o));
  a_r6_sck_rise_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> !cs_n_o);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> cs_n_o);
endmodule

bind spi_ctl_master spi_ctl_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .cs_n_o    (cs_n_o),
  .sck_o     (sck_o),
  .mosi_oe_o (mosi_oe_o),
  .rd_valid_o(rd_valid_o),
  .wr_take_o (wr_take_o)
);

// File: tb/sim_spi_ctl_master.sv
module sim_spi_ctl_master;
  localparam int DIV_W = 8;
  localparam int CNT_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DIV_W-1:0] div_i = 8'd22;
  logic start_i = 1'b0;
  logic [6:0] addr_i = '0;
  logic rnw_i = 1'b0;
  logic [CNT_W-1:0] nbytes_i = '0;
  logic [7:0] wdata_i;
  logic wr_take_o, rd_valid_o, busy_o, done_o, cs_n_o, sck_o, mosi_o, mosi_oe_o;
  logic [7:0] rd_data_o;
  logic miso_i = 1'b0;

  int tests = 0, fails = 0;
  int cyc = 0;
  int t_csf, t_first, t_rise, t_fall, t_csr, t_done;
  int rises, n_csf = 0, n_done = 0, n_rdv, widx, bad_ph, exp_half;
  logic oe_csr, busy_csr, busy_done;
  logic prev_cs = 1'b1, prev_sck = 1'b0;
  logic [0:63] mbits, obits;
  logic [7:0] rdv [0:7];

  always #4 clk = ~clk;

  function automatic logic [7:0] wpat(int k);
    return 8'(8'h3C + k * 8'h47);
  endfunction
  function automatic logic [7:0] rpat(int k);
    return 8'(8'hC9 ^ (k * 8'h35));
  endfunction
  function automatic logic mbit(int r);
    logic [7:0] b;
    if (r < 8) return 1'b0;
    b = rpat((r - 8) / 8);
    return b[7 - ((r - 8) % 8)];
  endfunction

  assign wdata_i = wpat(widx);

  spi_ctl_master u0 (
    .clk_i(clk), .rst_ni(rst_ni), .div_i(div_i), .start_i(start_i),
    .addr_i(addr_i), .rnw_i(rnw_i), .nbytes_i(nbytes_i), .wdata_i(wdata_i),
    .wr_take_o(wr_take_o), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .sck_o(sck_o),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // slave model and edge monitor
  always @(negedge clk) begin
    if (prev_cs && !cs_n_o) begin
      t_csf = cyc; rises = 0; n_csf++; miso_i = mbit(0);
    end
    if (!prev_sck && sck_o) begin
      if (rises == 0) t_first = cyc;
      else if (cyc - t_fall != exp_half) bad_ph++;
      if (rises < 64) begin mbits[rises] = mosi_o; obits[rises] = mosi_oe_o; end
      rises++; t_rise = cyc;
    end
    if (prev_sck && !sck_o) begin
      if (cyc - t_rise != exp_half) bad_ph++;
      t_fall = cyc; miso_i = mbit(rises);
    end
    if (!prev_cs && cs_n_o) begin
      t_csr = cyc; oe_csr = mosi_oe_o; busy_csr = busy_o;
    end
    if (done_o) begin t_done = cyc; busy_done = busy_o; n_done++; end
    if (rd_valid_o) begin
      if (n_rdv < 8) rdv[n_rdv] = rd_data_o;
      n_rdv++;
    end
    if (wr_take_o) widx++;
    prev_cs = cs_n_o; prev_sck = sck_o;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gbyte(int k);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7 - i] = mbits[8 * k + i];
    return int'(b);
  endfunction

  task automatic run(int dv, int ad, int rw, int n, bit inject);
    int e, h, csf0, done0, guard, bad_oe;
    e = dv & ~1; if (e < 22) e = 22; h = e / 2;
    exp_half = h; widx = 0; n_rdv = 0; bad_ph = 0;
    csf0 = n_csf; done0 = n_done;
    @(negedge clk);
    div_i = DIV_W'(dv); addr_i = 7'(ad); rnw_i = rw[0]; nbytes_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      repeat (60) @(negedge clk);
      addr_i = ~addr_i; rnw_i = ~rnw_i; nbytes_i = '0; div_i = 8'd60;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (n_done == done0 && guard < 20000) begin @(negedge clk); guard++; end
    if (n_done == done0) begin
      chk("R5 timeout", 1, 0);
      return;
    end
    chk("R3 lead", t_first - t_csf, 11 + h);
    chk("R2 phase widths", bad_ph, 0);
    chk("R4 lag", t_csr - t_fall, 11 + h);
    chk("R5 gap to done", t_done - t_csr, 3);
    chk("R5 busy at cs rise", int'(busy_csr), 1);
    chk("R5 busy in done cycle", int'(busy_done), 0);
    chk("R6 sck pulses", rises, 8 * (n + 1));
    chk("R6 address byte", gbyte(0), (ad % 128) * 2 + rw);
    if (rw == 0)
      for (int k = 1; k <= n; k++) chk("R7 write byte", gbyte(k), int'(wpat(k - 1)));
    chk("R7 take count", widx, (rw == 0) ? n : 0);
    bad_oe = 0;
    for (int r = 0; r < rises && r < 64; r++)
      if (obits[r] != ((r < 8) || rw == 0)) bad_oe++;
    chk("R8 oe during frame", bad_oe, 0);
    chk("R8 oe at cs rise", int'(oe_csr), 0);
    chk("R9 valid count", n_rdv, (rw == 1) ? n : 0);
    if (rw == 1)
      for (int k = 0; k < n; k++) chk("R9 read byte", int'(rdv[k]), int'(rpat(k)));
    if (inject) chk("R10 single select", n_csf - csf0, 1);
    chk("R1 idle after run", int'({cs_n_o, sck_o, mosi_oe_o, busy_o}), 4'b1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cs/sck/oe", int'({cs_n_o, sck_o, mosi_oe_o}), 3'b100);
    chk("R1 reset strobes", int'({busy_o, done_o, rd_valid_o, wr_take_o}), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle no start", int'({cs_n_o, sck_o, mosi_oe_o, busy_o, done_o}), 5'b10000);
    begin
      int dvs [5] = '{22, 24, 31, 10, 40};
      int idx = 0;
      foreach (dvs[d])
        for (int n = 0; n < 4; n++)
          for (int rw = 0; rw < 2; rw++) begin
            run(dvs[d], 13 * idx + 5, rw, n, 1'b0);
            idx++;
          end
    end
    run(26, 7'h55, 0, 3, 1'b1);
    run(22, 7'h2A, 1, 2, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    fails++; tests++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule